// File: doc/BRIEF.md
# Device Test Vector Sequencer

The sequencer takes one test vector at a time from a valid/ready stream and plays it onto the pins of a device under test. A vector holds a 4-bit symbol for each pin. Each pin is either driven to a static level, given a clock waveform, released, or checked against an expected response. The symbols are applied in fixed phases, and every phase lasts a parameterised number of cycles. Static levels come first and settle. Clock pins are then pulsed or stepped. After a settle window, the sensed pin levels and their high-impedance flags are compared once. The vector ends with a pass/fail verdict and a mask of the pins that failed.

The block only checks function. It knows nothing about timing margins. Every clock-class pin returns to a defined level before the compare, so the compare always sees settled logic.

Top module: `vecseq_top`

## Requirements
- R1: After reset `vec_ready` is 1, every `pin_oe` bit is 0 and `res_valid` is 0. A vector is taken when `vec_valid` and `vec_ready` are both 1 at a clock edge. `vec_ready` stays 0 from the next cycle until the result appears.
- R2: A pin with symbol code 0 or 1 is driven (`pin_oe`=1) to that level from the first cycle after acceptance. The level holds unchanged through the compare.
- R3: For the first LEVEL_CYC cycles after acceptance (the level phase), a pin with a clock-class symbol (C=2, K=3, U=4, D=5) keeps the drive it had before the vector.
- R4: Symbol C drives low, then high, then low, and symbol K drives high, then low, then high. Each part lasts HALF_CYC cycles and the waveform starts right after the level phase. Both are back at their idle level during the settle phase.
- R5: Symbol U drives high and symbol D drives low, from the start of the clock phase. The level holds through the settle phase and the compare.
- R6: Symbols X=6, F=7, L=8, H=9 and Z=10 leave the pin undriven from the first cycle after acceptance, even when the pin was driven by the previous vector.
- R7: At the compare, L fails unless the pin reads 0 and is not high impedance. H fails unless the pin reads 1 and is not high impedance. Z fails unless the high-impedance flag is set. Every other legal symbol passes. `res_fail_mask` bit p is set for each failing pin p.
- R8: `res_valid` rises SETTLE_CYC cycles after the clock phase ends. `res_pass` is 1 exactly when the mask is zero. The result stays unchanged until the next vector is accepted, and `res_valid` drops in the cycle after acceptance.
- R9: Codes 11 to 15 are illegal. Such a pin is never driven, its mask bit is set and `res_illegal` is 1.
- R10: While no vector is in progress, every pin keeps the drive enable and level it had at the end of the previous vector.

Pin p's symbol sits in `vec_sym[4p+3:4p]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vec_valid | input | 1 | A vector is offered |
| vec_ready | output | 1 | The sequencer can take a vector |
| vec_sym | input | NPINS*4 | One 4-bit symbol per pin |
| pin_oe | output | NPINS | Drive enable per pin |
| pin_out | output | NPINS | Drive level per pin |
| pin_in | input | NPINS | Sensed pin level |
| pin_hiz | input | NPINS | Sensed pin is high impedance |
| res_valid | output | 1 | A result is available |
| res_pass | output | 1 | Every pin met its expectation |
| res_fail_mask | output | NPINS | Pins that failed |
| res_illegal | output | 1 | The vector held an illegal code |

## Verification
The bench goes after the following corner cases:
- A pin that switches from a driven level to a check symbol. A design that released it late would fight the device for the whole level phase.
- Clock pins across the level phase. A design that applied clocks early would give them an edge before the data had settled.
- The end of a C or K pulse. A design that sampled before the pulse returned would compare against a half-clocked device.
- A Z expectation on a pin that reads as a firm 0 or 1, and an L or H expectation on a floating pin. Each must fail, and a design that checked only the level would pass them.
- Illegal codes. These must fail the vector even though nothing on the pin looks wrong.

// File: rtl/vecseq_pkg.sv
package vecseq_pkg;

   localparam int SYM_W = 4;

   localparam logic [SYM_W-1:0] SYM_0 = 4'd0;
   localparam logic [SYM_W-1:0] SYM_1 = 4'd1;
   localparam logic [SYM_W-1:0] SYM_C = 4'd2;
   localparam logic [SYM_W-1:0] SYM_K = 4'd3;
   localparam logic [SYM_W-1:0] SYM_U = 4'd4;
   localparam logic [SYM_W-1:0] SYM_D = 4'd5;
   localparam logic [SYM_W-1:0] SYM_X = 4'd6;
   localparam logic [SYM_W-1:0] SYM_F = 4'd7;
   localparam logic [SYM_W-1:0] SYM_L = 4'd8;
   localparam logic [SYM_W-1:0] SYM_H = 4'd9;
   localparam logic [SYM_W-1:0] SYM_Z = 4'd10;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_LEVEL,
      PH_CLKA,
      PH_CLKB,
      PH_CLKC,
      PH_SETTLE
   } phase_e;

   function automatic logic sym_is_level(input logic [SYM_W-1:0] s);
      return (s == SYM_0) || (s == SYM_1);
   endfunction

   function automatic logic sym_is_clock(input logic [SYM_W-1:0] s);
      return (s == SYM_C) || (s == SYM_K) || (s == SYM_U) || (s == SYM_D);
   endfunction

   function automatic logic sym_is_legal(input logic [SYM_W-1:0] s);
      return s <= SYM_Z;
   endfunction

endpackage

// File: rtl/vecseq_ctrl.sv
module vecseq_ctrl
   import vecseq_pkg::*;
#(
   parameter int LEVEL_CYC  = 2,
   parameter int HALF_CYC   = 2,
   parameter int SETTLE_CYC = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   vec_valid,
   output logic   vec_ready,
   output logic   accept,
   output phase_e phase,
   output logic   sample
);

   localparam int MAX_AB = (LEVEL_CYC > HALF_CYC) ? LEVEL_CYC : HALF_CYC;
   localparam int MAXC   = (MAX_AB > SETTLE_CYC) ? MAX_AB : SETTLE_CYC;
   localparam int CW     = $clog2(MAXC + 1);

   phase_e        ph_q, ph_n;
   logic [CW-1:0] cnt_q, lim;
   logic          last;

   always_comb begin
      case (ph_q)
         PH_LEVEL:                   lim = CW'(LEVEL_CYC - 1);
         PH_CLKA, PH_CLKB, PH_CLKC:  lim = CW'(HALF_CYC - 1);
         PH_SETTLE:                  lim = CW'(SETTLE_CYC - 1);
         default:                    lim = '0;
      endcase
   end

   assign last      = (cnt_q == lim);
   assign vec_ready = (ph_q == PH_IDLE);
   assign accept    = vec_valid && vec_ready;
   assign sample    = (ph_q == PH_SETTLE) && last;
   assign phase     = ph_q;

   always_comb begin
      ph_n = ph_q;
      case (ph_q)
         PH_IDLE:   if (accept) ph_n = PH_LEVEL;
         PH_LEVEL:  if (last)   ph_n = PH_CLKA;
         PH_CLKA:   if (last)   ph_n = PH_CLKB;
         PH_CLKB:   if (last)   ph_n = PH_CLKC;
         PH_CLKC:   if (last)   ph_n = PH_SETTLE;
         PH_SETTLE: if (last)   ph_n = PH_IDLE;
         default:               ph_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         ph_q <= ph_n;
         if (ph_n != ph_q || ph_q == PH_IDLE)
            cnt_q <= '0;
         else
            cnt_q <= cnt_q + 1'b1;
      end
   end

   AST_CLK_AFTER_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_CLKA && $past(ph_q) != PH_CLKA) |-> $past(ph_q) == PH_LEVEL) else $error("AST_CLK_AFTER_LEVEL"); // R3
   AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !vec_ready) else $error("AST_BUSY_AFTER_ACCEPT"); // R1

endmodule

// File: rtl/vecseq_pin.sv
module vecseq_pin
   import vecseq_pkg::*;
#(
   parameter int SENSE_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic [SYM_W-1:0] sym_in,
   input  phase_e           phase,
   input  logic             sample,
   input  logic             pin_in,
   input  logic             pin_hiz,
   output logic             oe,
   output logic             val,
   output logic             fail,
   output logic             illegal
);

   logic [SYM_W-1:0] sym_q;
   logic             oe_h, val_h;
   logic             s_in, s_hz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sym_q <= SYM_X;
      else if (accept) sym_q <= sym_in;
   end

   generate
      if (SENSE_STAGES == 0) begin : g_direct
         assign s_in = pin_in;
         assign s_hz = pin_hiz;
      end else begin : g_flop
         logic [SENSE_STAGES-1:0] in_p, hz_p;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               in_p <= '0;
               hz_p <= '1;
            end else begin
               in_p[0] <= pin_in;
               hz_p[0] <= pin_hiz;
               for (int i = 1; i < SENSE_STAGES; i++) begin
                  in_p[i] <= in_p[i-1];
                  hz_p[i] <= hz_p[i-1];
               end
            end
         end
         assign s_in = in_p[SENSE_STAGES-1];
         assign s_hz = hz_p[SENSE_STAGES-1];
      end
   endgenerate

   always_comb begin
      oe  = 1'b0;
      val = 1'b0;
      if (phase == PH_IDLE) begin
         oe  = oe_h;
         val = val_h;
      end else if (sym_is_level(sym_q)) begin
         oe  = 1'b1;
         val = sym_q[0];
      end else if (sym_is_clock(sym_q)) begin
         if (phase == PH_LEVEL) begin
            oe  = oe_h;
            val = val_h;
         end else begin
            oe = 1'b1;
            case (sym_q)
               SYM_C:   val = (phase == PH_CLKB);
               SYM_K:   val = (phase != PH_CLKB);
               SYM_U:   val = 1'b1;
               default: val = 1'b0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_h  <= 1'b0;
         val_h <= 1'b0;
      end else begin
         oe_h  <= oe;
         val_h <= val;
      end
   end

   assign illegal = !sym_is_legal(sym_q);

   always_comb begin
      case (sym_q)
         SYM_L:   fail = s_hz | s_in;
         SYM_H:   fail = s_hz | ~s_in;
         SYM_Z:   fail = ~s_hz;
         default: fail = illegal;
      endcase
   end

   AST_PULSE_IDLE_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && (sym_q == SYM_C || sym_q == SYM_K)) |-> (oe && val == (sym_q == SYM_K))) else $error("AST_PULSE_IDLE_AT_SAMPLE"); // R4
   AST_CHECK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && !sym_is_level(sym_q) && !sym_is_clock(sym_q)) |-> !oe) else $error("AST_CHECK_RELEASED"); // R6
   AST_LEVEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_IDLE && phase != PH_LEVEL && sym_is_level(sym_q)) |-> (oe && $stable(val))) else $error("AST_LEVEL_STEADY"); // R2

endmodule

// File: rtl/vecseq_top.sv
module vecseq_top
   import vecseq_pkg::*;
#(
   parameter int NPINS        = 8,
   parameter int LEVEL_CYC    = 2,
   parameter int HALF_CYC     = 2,
   parameter int SETTLE_CYC   = 2,
   parameter int SENSE_STAGES = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   vec_valid,
   output logic                   vec_ready,
   input  logic [NPINS*SYM_W-1:0] vec_sym,
   output logic [NPINS-1:0]       pin_oe,
   output logic [NPINS-1:0]       pin_out,
   input  logic [NPINS-1:0]       pin_in,
   input  logic [NPINS-1:0]       pin_hiz,
   output logic                   res_valid,
   output logic                   res_pass,
   output logic [NPINS-1:0]       res_fail_mask,
   output logic                   res_illegal
);

   generate
      if (NPINS < 1) begin : g_bad_npins
         $error("NPINS must be at least 1");
      end
      if (LEVEL_CYC < 1 || HALF_CYC < 1 || SETTLE_CYC < 1) begin : g_bad_cyc
         $error("phase lengths must be at least 1");
      end
      if (SENSE_STAGES < 0 || SETTLE_CYC <= SENSE_STAGES) begin : g_bad_sense
         $error("SETTLE_CYC must exceed SENSE_STAGES");
      end
   endgenerate

   logic             accept, sample;
   phase_e           phase;
   logic [NPINS-1:0] fail_v, ill_v;

   vecseq_ctrl #(
      .LEVEL_CYC  (LEVEL_CYC),
      .HALF_CYC   (HALF_CYC),
      .SETTLE_CYC (SETTLE_CYC)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .vec_valid (vec_valid),
      .vec_ready (vec_ready),
      .accept    (accept),
      .phase     (phase),
      .sample    (sample)
   );

   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      vecseq_pin #(
         .SENSE_STAGES (SENSE_STAGES)
      ) u_pin (
         .clk     (clk),
         .rst_n   (rst_n),
         .accept  (accept),
         .sym_in  (vec_sym[p*SYM_W +: SYM_W]),
         .phase   (phase),
         .sample  (sample),
         .pin_in  (pin_in[p]),
         .pin_hiz (pin_hiz[p]),
         .oe      (pin_oe[p]),
         .val     (pin_out[p]),
         .fail    (fail_v[p]),
         .illegal (ill_v[p])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_pass      <= 1'b0;
         res_fail_mask <= '0;
         res_illegal   <= 1'b0;
      end else if (accept) begin
         res_valid     <= 1'b0;
         res_pass      <= 1'b0;
         res_fail_mask <= '0;
         res_illegal   <= 1'b0;
      end else if (sample) begin
         res_valid     <= 1'b1;
         res_pass      <= (fail_v == '0);
         res_fail_mask <= fail_v;
         res_illegal   <= |ill_v;
      end
   end

   AST_PASS_MATCHES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_pass == (res_fail_mask == '0))) else $error("AST_PASS_MATCHES_MASK"); // R8
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !(vec_valid && vec_ready)) |=> (res_valid && $stable(res_fail_mask))) else $error("AST_RESULT_HELD"); // R8
   AST_ILLEGAL_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
      res_illegal |-> (res_fail_mask != '0 && !res_pass)) else $error("AST_ILLEGAL_FAILS"); // R9
   AST_NO_READY_BEFORE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vec_ready) |-> $rose(res_valid)) else $error("AST_NO_READY_BEFORE_RESULT"); // R1

endmodule

// File: tb/sim_vecseq_top.sv
module sim_vecseq_top;

   localparam int N     = 8;
   localparam int LC    = 2;
   localparam int HC    = 2;
   localparam int SC    = 2;
   localparam int TOTAL = LC + 3*HC + SC;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           vec_valid = 1'b0;
   logic           vec_ready;
   logic [4*N-1:0] vec_sym = '0;
   logic [N-1:0]   pin_oe, pin_out;
   logic [N-1:0]   pin_in = '0;
   logic [N-1:0]   pin_hiz = '0;
   logic           res_valid, res_pass, res_illegal;
   logic [N-1:0]   res_fail_mask;

   int errors = 0;
   int checks = 0;
   logic [N-1:0] m_oe = '0;
   logic [N-1:0] m_val = '0;

   always #10 clk = ~clk;

   vecseq_top #(
      .NPINS(N), .LEVEL_CYC(LC), .HALF_CYC(HC), .SETTLE_CYC(SC), .SENSE_STAGES(1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
      .vec_sym(vec_sym), .pin_oe(pin_oe), .pin_out(pin_out), .pin_in(pin_in),
      .pin_hiz(pin_hiz), .res_valid(res_valid), .res_pass(res_pass),
      .res_fail_mask(res_fail_mask), .res_illegal(res_illegal)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // phase index: 1 level, 2..4 clock parts, 5 settle
   function automatic int phase_of(input int k);
      if (k <= LC)        return 1;
      if (k <= LC + HC)   return 2;
      if (k <= LC + 2*HC) return 3;
      if (k <= LC + 3*HC) return 4;
      return 5;
   endfunction

   function automatic logic [1:0] exp_drv(input logic [3:0] s, input int ph, input logic po, input logic pv);
      if (s == 4'd0 || s == 4'd1) return {1'b1, s[0]};
      if (s >= 4'd2 && s <= 4'd5) begin
         if (ph == 1) return {po, pv};
         case (s)
            4'd2:    return {1'b1, ph == 3};
            4'd3:    return {1'b1, ph != 3};
            4'd4:    return 2'b11;
            default: return 2'b10;
         endcase
      end
      return 2'b00;
   endfunction

   function automatic logic exp_fail(input logic [3:0] s, input logic i, input logic h);
      case (s)
         4'd8:    return h | i;
         4'd9:    return h | ~i;
         4'd10:   return ~h;
         default: return s > 4'd10;
      endcase
   endfunction

   function automatic string tag_of(input int ph);
      case (ph)
         1:       return "R2,R3,R6 level phase drive";
         2, 3, 4: return "R4,R5 clock phase drive";
         default: return "R2,R4,R5 settle phase drive";
      endcase
   endfunction

   task automatic run_vec(input logic [4*N-1:0] s, input logic [N-1:0] iv, input logic [N-1:0] hv, input int gap);
      logic [N-1:0] eo, ev, emask;
      logic eill;
      @(negedge clk);
      chk(vec_ready === 1'b1, "R1 ready while idle", vec_ready, 1);
      vec_valid = 1'b1;
      vec_sym   = s;
      pin_in    = iv;
      pin_hiz   = hv;
      @(negedge clk);
      vec_valid = 1'b0;
      vec_sym   = ~s;
      for (int k = 1; k <= TOTAL; k++) begin
         int ph;
         ph = phase_of(k);
         for (int p = 0; p < N; p++) begin
            logic [1:0] d;
            d = exp_drv(s[4*p +: 4], ph, m_oe[p], m_val[p]);
            eo[p] = d[1];
            ev[p] = d[0];
         end
         m_oe  = eo;
         m_val = ev;
         chk(pin_oe === eo && (pin_out & eo) === (ev & eo), tag_of(ph),
             {16'd0, pin_oe, pin_out & pin_oe}, {16'd0, eo, ev & eo});
         chk(vec_ready === 1'b0 && res_valid === 1'b0, "R1 busy: no ready, no result",
             {vec_ready, res_valid}, 0);
         @(negedge clk);
      end
      eill = 1'b0;
      for (int p = 0; p < N; p++) begin
         emask[p] = exp_fail(s[4*p +: 4], iv[p], hv[p]);
         if (s[4*p +: 4] > 4'd10) eill = 1'b1;
      end
      chk(res_valid === 1'b1, "R8 result valid after settle", res_valid, 1);
      chk(res_fail_mask === emask, "R7 fail mask", res_fail_mask, emask);
      chk(res_pass === (emask == '0), "R8 pass flag", res_pass, emask == '0);
      chk(res_illegal === eill, "R9 illegal flag", res_illegal, eill);
      for (int g = 0; g < gap; g++) begin
         chk(pin_oe === m_oe && (pin_out & m_oe) === (m_val & m_oe), "R10 idle hold",
             {pin_oe, pin_out}, {m_oe, m_val});
         chk(res_valid === 1'b1 && res_fail_mask === emask, "R8 result held",
             res_fail_mask, emask);
         @(negedge clk);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [4*N-1:0] s;
      logic [N-1:0] iv, hv;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(vec_ready === 1'b1 && pin_oe === '0 && res_valid === 1'b0, "R1 reset state",
          {vec_ready, pin_oe, res_valid}, {1'b1, 8'h00, 1'b0});
      rst_n = 1'b1;

      // R2: alternating static levels
      for (int p = 0; p < N; p++) s[4*p +: 4] = 4'(p % 2);
      run_vec(s, '0, '0, 2);

      // R3,R4,R5: clock-class symbols hold across level phase, then pulse or step
      for (int p = 0; p < N; p++) s[4*p +: 4] = 4'(2 + (p % 4));
      run_vec(s, '0, '0, 3);

      // R6,R7: previously driven pins turn into checks; matching and failing responses
      s = {4'd10, 4'd10, 4'd9, 4'd9, 4'd8, 4'd8, 4'd7, 4'd6};
      iv = 8'b0101_0100;
      hv = 8'b1000_0001;
      run_vec(s, iv, hv, 2);

      // R7: Z against firm levels, L and H against a floating pin
      s = {4'd10, 4'd10, 4'd8, 4'd9, 4'd0, 4'd1, 4'd2, 4'd3};
      run_vec(s, 8'b1000_0000, 8'b0011_0000, 2);

      // R9: illegal codes on two pins
      s = {4'd15, 4'd0, 4'd0, 4'd0, 4'd11, 4'd1, 4'd1, 4'd1};
      run_vec(s, '0, '0, 2);

      for (int v = 0; v < 150; v++) begin
         for (int p = 0; p < N; p++) s[4*p +: 4] = 4'($urandom_range(0, 10));
         if ($urandom_range(0, 7) == 0) s[4*$urandom_range(0, N-1) +: 4] = 4'($urandom_range(11, 15));
         iv = N'($urandom);
         hv = N'($urandom) & N'($urandom);
         run_vec(s, iv, hv, int'($urandom_range(0, 3)));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule